// File: doc/BRIEF.md
# Card-Detect Interrupt Status Controller

This block is a single 32-bit memory-mapped interrupt word for a removable-card host port. The lower half of the word shows event and status bits. The upper half holds one enable bit for each of those positions, sitting exactly sixteen places higher. Several sources feed the block:

- a debounced card-present level;
- a FIFO-empty level;
- single-cycle pulses from the DMA engine (completion and failure);
- single-cycle pulses from the FIFO datapath (read while empty, length mismatch);
- an activity pulse that lights the status LED.

The block drives one level-sensitive interrupt line and the LED output.

Software arms insert or remove detection according to whether a card is currently present. It waits for the interrupt, then acknowledges each event by writing a zero into its status bit. Writing a one into a status bit leaves that bit alone, so a read-modify-write that clears one event cannot disturb the others. The enable half is written as plain data on every write.

Top module: `cd_irq_ctrl`

## Requirements
- R1: After reset, every event bit, enable bit, the LED bit and the interrupt output are 0.
- R2: On a write, bits 31..16 take the written value and read back unchanged. Enable bit n+16 belongs to status bit n.
- R3: Writing 0 to an event bit (8, 9, 11, 12, 13, 14) clears it. Writing 1 to it leaves it unchanged. With no write and no new event, it keeps its value.
- R4: Bit 1 reads the card-present input level, and writes have no effect on it.
- R5: Bit 8 (insert) is set by a rising edge of card-present only while bit 24 is 1. A rising edge seen with bit 24 at 0 sets nothing.
- R6: Bit 9 (remove) is set by a falling edge of card-present only while bit 25 is 1. A falling edge seen with bit 25 at 0 sets nothing.
- R7: Bit 10 reads the FIFO-empty level and cannot be cleared by a write. Bit 11 latches a DMA-done pulse. Bit 14 latches a DMA-error pulse.
- R8: Bit 12 latches an empty-FIFO-read pulse. Bit 13 latches a length-mismatch pulse.
- R9: Bit 15 is set by an activity pulse and cleared only by writing 0 to it. The LED output equals bit 15.
- R10: The interrupt output is 1 exactly when some bit in 14..8 (mask 0x7F00) is 1 together with its enable in 30..24 (mask 0x7F000000). Enables at 23..16 and 31 never raise it.
- R11: When a hardware set and a software clear of the same bit happen in the same cycle, the bit ends up set.
- R12: Bits 0 and 7..2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Debounced card-present level |
| fifo_empty_i | input | 1 | FIFO-empty level |
| dma_done_i | input | 1 | DMA completion pulse |
| dma_err_i | input | 1 | DMA failure pulse |
| fifo_underrun_i | input | 1 | Pulse: software read the FIFO while empty |
| fifo_mismatch_i | input | 1 | Pulse: FIFO fill does not match transfer length |
| led_set_i | input | 1 | Activity pulse that turns the LED on |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register word |
| irq_o | output | 1 | Level interrupt |
| led_o | output | 1 | Activity LED drive |

## Verification
Each event is latched on the clock edge that samples its source pulse, or the card-present edge. A wrong latch, a missed arm check or a lost acknowledge therefore shows on the register read and on the interrupt line one cycle after the stimulus. The edge detector's memory of the previous presence level is not visible directly. A stale value of it shows up as a spurious or missing insert or remove bit right after presence changes. The same-cycle race between a pulse and a zero write is driven on purpose, because a wrong priority would silently drop an event.

// File: rtl/cd_irq_ctrl.sv
module cd_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        card_present_i,
  input  logic        fifo_empty_i,
  input  logic        dma_done_i,
  input  logic        dma_err_i,
  input  logic        fifo_underrun_i,
  input  logic        fifo_mismatch_i,
  input  logic        led_set_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o,
  output logic        led_o
);
  localparam int EnOfs = 16;
  localparam int BIns  = 8;
  localparam int BRem  = 9;
  localparam int BDone = 11;
  localparam int BOrun = 12;
  localparam int BMism = 13;
  localparam int BErr  = 14;
  localparam int BLed  = 15;

  logic [15:0] en_q;
  logic        pres_q;
  logic        ins_q, rem_q, done_q, orun_q, mism_q, err_q, led_q;
  logic        rise, fall;
  logic [15:0] stat;

  assign rise = card_present_i & ~pres_q;
  assign fall = ~card_present_i & pres_q;

  function automatic logic upd(input logic cur, input logic set, input int b,
                               input logic we, input logic [31:0] wd);
    return set | (cur & ~(we & ~wd[b]));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pres_q <= 1'b0;
      ins_q  <= 1'b0;
      rem_q  <= 1'b0;
      done_q <= 1'b0;
      orun_q <= 1'b0;
      mism_q <= 1'b0;
      err_q  <= 1'b0;
      led_q  <= 1'b0;
    end else begin
      pres_q <= card_present_i;
      if (wr_en_i) en_q <= wr_data_i[31:16];
      ins_q  <= upd(ins_q,  rise & en_q[BIns], BIns, wr_en_i, wr_data_i);
      rem_q  <= upd(rem_q,  fall & en_q[BRem], BRem, wr_en_i, wr_data_i);
      done_q <= upd(done_q, dma_done_i,      BDone, wr_en_i, wr_data_i);
      orun_q <= upd(orun_q, fifo_underrun_i, BOrun, wr_en_i, wr_data_i);
      mism_q <= upd(mism_q, fifo_mismatch_i, BMism, wr_en_i, wr_data_i);
      err_q  <= upd(err_q,  dma_err_i,       BErr,  wr_en_i, wr_data_i);
      led_q  <= upd(led_q,  led_set_i,       BLed,  wr_en_i, wr_data_i);
    end
  end

  assign stat = {led_q, err_q, mism_q, orun_q, done_q, fifo_empty_i, rem_q, ins_q,
                 6'b0, card_present_i, 1'b0};

  assign rd_data_o = {en_q, stat};
  assign irq_o     = |(stat[14:8] & en_q[14:8]);
  assign led_o     = led_q;

  assert_w0c_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[BDone] && !dma_done_i) |=> !rd_data_o[BDone]);

  assert_hold_ins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && rd_data_o[BIns]) |=> rd_data_o[BIns]);

  assert_insert_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(card_present_i) && rd_data_o[BIns + EnOfs]) |=> rd_data_o[BIns]);

  assert_remove_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_present_i) && rd_data_o[BRem + EnOfs]) |=> rd_data_o[BRem]);

  assert_led_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (led_o && !(wr_en_i && !wr_data_i[BLed])) |=> led_o);

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rd_data_o[30:24] != 7'd0));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_err_i |=> rd_data_o[BErr]);

  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[0] == 1'b0) && (rd_data_o[7:2] == 6'd0));
endmodule

// File: tb/cd_irq_ctrl_bench.sv
module cd_irq_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pres = 1'b0, fempty = 1'b0, ddone = 1'b0, derr = 1'b0;
  logic orun = 1'b0, mism = 1'b0, ledset = 1'b0, we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic irq, led;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cd_irq_ctrl u_cd_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .card_present_i(pres), .fifo_empty_i(fempty),
    .dma_done_i(ddone), .dma_err_i(derr), .fifo_underrun_i(orun),
    .fifo_mismatch_i(mism), .led_set_i(ledset), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .irq_o(irq), .led_o(led));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic t_reset;
    chk("R1 word", rd, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 led", {31'b0, led}, 32'h0);
  endtask

  task automatic t_enable;
    wr(32'hFFFF_0000);
    chk("R2 enables readback", rd, 32'hFFFF_0000);
    wr(32'h1234_0000);
    chk("R2 enables rewrite", rd, 32'h1234_0000);
    wr(32'h0);
    chk("R2 enables cleared", rd, 32'h0);
  endtask

  task automatic t_present;
    pres = 1'b1; tick; tick;
    chk("R4 present level", rd, 32'h0000_0002);
    chk("R5 disarmed rise ignored", {31'b0, rd[8]}, 32'h0);
    wr(32'h0);
    chk("R4 write ignored", {31'b0, rd[1]}, 32'h1);
    chk("R12 unused bits", rd & 32'h0000_00FD, 32'h0);
  endtask

  task automatic t_insert;
    pres = 1'b0; tick; tick;
    chk("R6 disarmed fall ignored", {31'b0, rd[9]}, 32'h0);
    wr(32'h0100_0000);
    pres = 1'b1; tick;
    chk("R5 insert latched", rd, 32'h0100_0102);
    chk("R10 irq on insert", {31'b0, irq}, 32'h1);
    wr(32'h0100_0000);
    chk("R3 insert acked", rd, 32'h0100_0002);
    chk("R10 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_remove;
    wr(32'h0200_0000);
    pres = 1'b0; tick;
    chk("R6 remove latched", rd, 32'h0200_0200);
    chk("R10 irq on remove", {31'b0, irq}, 32'h1);
    wr(32'h0200_FFFF);
    chk("R3 write one keeps", {31'b0, rd[9]}, 32'h1);
    wr(32'h0200_0000);
    chk("R3 remove acked", {31'b0, rd[9]}, 32'h0);
  endtask

  task automatic t_dma;
    wr(32'h0);
    ddone = 1'b1; tick; ddone = 1'b0;
    chk("R7 dma done latched", rd, 32'h0000_0800);
    chk("R10 no irq unenabled", {31'b0, irq}, 32'h0);
    wr(32'h0800_0800);
    chk("R10 irq enabled done", {31'b0, irq}, 32'h1);
    fempty = 1'b1; tick;
    wr(32'h0800_0800);
    chk("R7 fifo empty level", {31'b0, rd[10]}, 32'h1);
    fempty = 1'b0; tick;
    chk("R7 fifo empty follows", {31'b0, rd[10]}, 32'h0);
    derr = 1'b1; tick; derr = 1'b0;
    chk("R7 dma error latched", {31'b0, rd[14]}, 32'h1);
    wr(32'h0);
    chk("R3 all acked", rd, 32'h0);
  endtask

  task automatic t_fifo;
    orun = 1'b1; tick; orun = 1'b0;
    chk("R8 underrun", rd, 32'h0000_1000);
    mism = 1'b1; tick; mism = 1'b0;
    chk("R8 mismatch", rd, 32'h0000_3000);
    wr(32'h0000_2FFF);
    chk("R3 selective ack", rd, 32'h0000_2000);
    wr(32'h0);
  endtask

  task automatic t_led;
    ledset = 1'b1; tick; ledset = 1'b0;
    chk("R9 led on", {rd[15], 30'b0, led}, 32'h8000_0001);
    wr(32'h0000_FFFF);
    chk("R9 led kept", {31'b0, led}, 32'h1);
    wr(32'h0000_7FFF);
    chk("R9 led cleared", {rd[15], 30'b0, led}, 32'h0);
  endtask

  task automatic t_mask;
    ddone = 1'b1; derr = 1'b1; orun = 1'b1; mism = 1'b1; tick;
    ddone = 1'b0; derr = 1'b0; orun = 1'b0; mism = 1'b0;
    wr(32'h80FF_FFFF);
    chk("R10 outer enables ignored", {31'b0, irq}, 32'h0);
    wr(32'h4000_FFFF);
    chk("R10 err enable", {31'b0, irq}, 32'h1);
    wr(32'h0);
  endtask

  task automatic t_race;
    @(negedge clk); we = 1'b1; wd = 32'h0; derr = 1'b1;
    @(negedge clk); we = 1'b0; derr = 1'b0;
    chk("R11 set beats clear", {31'b0, rd[14]}, 32'h1);
    wr(32'h0);
    chk("R11 later ack", rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick;
    t_reset; t_enable; t_present; t_insert; t_remove;
    t_dma; t_fifo; t_led; t_mask; t_race;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule